// File: doc/BRIEF.md
# Streaming 3x3 Sobel Edge Filter

This block accepts a raster-order stream of 8-bit single-channel pixels and returns, for every input position, the approximate Sobel gradient magnitude of that pixel's 3x3 neighbourhood. Image width `W` and height `H` are parameters. Both the input and the output use a valid/ready handshake. The output side also marks the first pixel of each frame and the last pixel of each row.

Storage is a ring of 2·W+3 pixels, which is two image rows plus three pixels, not a frame buffer. Neighbours that fall outside the image are taken by reflecting across the edge, so the border needs no padding value and the output frame is the same size as the input frame. When the last input pixel has been accepted, the remaining outputs drain without any further input. A new frame may then follow directly.

Top module: `sobel_stream`

## Requirements
- R1: The block holds at most 2·W+3 pixels. The number of accepted input pixels may run ahead of the number of emitted output pixels by at most W+2. While the output is not being taken and that lead equals W+2, or while the whole frame has been accepted, `in_ready` is 0. Otherwise `in_ready` is 1.
- R2: The first output of a frame becomes valid in the cycle after the (W+2)-th input pixel of that frame is accepted, and not earlier.
- R3: With window pixels p1..p9 in raster order (p1 top-left, p5 centre, p9 bottom-right), the output is |(p1+2·p2+p3) − (p7+2·p8+p9)| + |(p3+2·p6+p9) − (p1+2·p4+p7)|. The arithmetic uses signed intermediates at least 12 bits wide.
- R4: Out-of-image neighbours are reflected without repeating the edge. Row −1 reads row 1, row H reads row H−2, column −1 reads column 1, and column W reads column W−2.
- R5: A magnitude above 255 is output as 255.
- R6: `out_sof` is 1 exactly on the first output of a frame. `out_eol` is 1 exactly on outputs in column W−1.
- R7: Each frame of W·H accepted pixels yields exactly W·H outputs in raster order. The final outputs are flushed with no further input, and `out_valid` is 0 once the frame has drained.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output pixel and markers hold steady. No pixel is lost or duplicated under stalls on either side.
- R9: Frames may follow one another back to back, and each frame is processed independently of the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can accept an input pixel |
| in_pix | input | 8 | Input pixel value |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_pix | output | 8 | Saturated gradient magnitude |
| out_sof | output | 1 | First output pixel of the frame |
| out_eol | output | 1 | Last output pixel of a row |

## Verification
Embedded assertions check the following on every cycle:
- the input lead never exceeds W+2 pixels;
- the first valid output of a frame appears only once W+2 pixels are present;
- the output stays frozen while it is stalled;
- neither frame marker repeats on the output that follows it.

The arithmetic, the border reflection and the saturation can only be shown by the bench's scenarios. The bench compares every output of several 8x6 frames against an independently computed reflected Sobel model. Those frames cover ramps, stripes, constant and scrambled content. Each frame is run under a different pattern of input gaps and output stalls, including a long initial stall that exercises the `in_ready` limit.

// File: rtl/sobel_stream.sv
module sobel_stream #(
  parameter int W = 8,
  parameter int H = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_pix,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_pix,
  output logic       out_sof,
  output logic       out_eol
);
  localparam int D  = 2 * W + 3;
  localparam int AW = $clog2(D);
  localparam int NP = W * H;
  localparam int NW = $clog2(NP + 1);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam int RW = (H > 2) ? $clog2(H) : 1;

  logic [7:0]    ring [D];
  logic [AW-1:0] wp, base;
  logic [NW-1:0] n_in, n_out;
  logic [CW-1:0] col;
  logic [RW-1:0] row;

  function automatic logic [AW-1:0] slot(input logic [AW-1:0] b, input int d);
    int s;
    s = int'(b) + d;
    if (s < 0) s = s + D;
    else if (s >= D) s = s - D;
    return AW'(s);
  endfunction

  wire out_fire = out_valid & out_ready;
  wire in_fire  = in_valid & in_ready;
  wire last_out = (n_out == NW'(NP - 1));

  assign out_valid = (int'(n_in) >= int'(n_out) + W + 2) || (n_in == NW'(NP));
  assign in_ready  = (int'(n_in) < NP) && ((int'(n_in) < int'(n_out) + W + 2) || out_fire);
  assign out_sof   = (n_out == '0);
  assign out_eol   = (col == CW'(W - 1));

  int up, dn, lf, rt;
  logic [7:0] p1, p2, p3, p4, p6, p7, p8, p9;
  int gx, gy, mag;

  always_comb begin
    up = (row == '0) ? W : -W;
    dn = (row == RW'(H - 1)) ? -W : W;
    lf = (col == '0) ? 1 : -1;
    rt = (col == CW'(W - 1)) ? -1 : 1;
    p1 = ring[slot(base, up + lf)];
    p2 = ring[slot(base, up)];
    p3 = ring[slot(base, up + rt)];
    p4 = ring[slot(base, lf)];
    p6 = ring[slot(base, rt)];
    p7 = ring[slot(base, dn + lf)];
    p8 = ring[slot(base, dn)];
    p9 = ring[slot(base, dn + rt)];
    gy = (int'(p1) + 2 * int'(p2) + int'(p3)) - (int'(p7) + 2 * int'(p8) + int'(p9));
    gx = (int'(p3) + 2 * int'(p6) + int'(p9)) - (int'(p1) + 2 * int'(p4) + int'(p7));
    mag = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    out_pix = (mag > 255) ? 8'd255 : 8'(mag);
  end

  always_ff @(posedge clk)
    if (in_fire) ring[wp] <= in_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; base <= '0; n_in <= '0; n_out <= '0; col <= '0; row <= '0;
    end else begin
      if (in_fire) begin
        wp   <= (wp == AW'(D - 1)) ? '0 : wp + 1'b1;
        n_in <= n_in + 1'b1;
      end
      if (out_fire) begin
        if (last_out) begin
          wp <= '0; base <= '0; n_in <= '0; n_out <= '0; col <= '0; row <= '0;
        end else begin
          base  <= (base == AW'(D - 1)) ? '0 : base + 1'b1;
          n_out <= n_out + 1'b1;
          if (col == CW'(W - 1)) begin
            col <= '0;
            row <= row + 1'b1;
          end else begin
            col <= col + 1'b1;
          end
        end
      end
    end
  end

  // R1
  lead_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(n_in) - int'(n_out) <= W + 2);

  // R2
  first_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && out_sof) |-> (n_in == NW'(W + 2)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_sof) && $stable(out_eol)));

  // R6
  eol_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_eol) |=> !out_eol);

  // R6
  sof_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_sof && !last_out) |=> !out_sof);
endmodule

// File: tb/test_sobel_stream.sv
module test_sobel_stream;
  localparam int W = 8;
  localparam int H = 6;
  localparam int NP = W * H;
  localparam int NFR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_pix = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [7:0] out_pix;

  int checks = 0;
  int fails = 0;
  int img [H][W];

  always #2 clk = ~clk;

  sobel_stream #(.W(W), .H(H)) i_sobel_stream (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int refl(input int x, input int n);
    if (x < 0) return 1;
    if (x >= n) return n - 2;
    return x;
  endfunction

  function automatic int pix_at(input int r, input int c);
    return img[refl(r, H)][refl(c, W)];
  endfunction

  // R3 R4 R5 model
  function automatic int expect_out(input int r, input int c);
    int gx, gy, m;
    gy = (pix_at(r-1,c-1) + 2*pix_at(r-1,c) + pix_at(r-1,c+1))
       - (pix_at(r+1,c-1) + 2*pix_at(r+1,c) + pix_at(r+1,c+1));
    gx = (pix_at(r-1,c+1) + 2*pix_at(r,c+1) + pix_at(r+1,c+1))
       - (pix_at(r-1,c-1) + 2*pix_at(r,c-1) + pix_at(r+1,c-1));
    m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (m > 255) ? 255 : m;
  endfunction

  function automatic int pattern(input int f, input int r, input int c);
    case (f)
      0: return (r * 20 + c * 7) & 255;
      1: return (c % 2 == 1) ? 255 : 0;
      2: return ((r * 37 + c * 91 + 13) ^ (r * c * 5)) & 255;
      3: return 100;
      default: return ((r % 2 == 0) ? 255 : 0) ^ ((c * 29) & 63);
    endcase
  endfunction

  function automatic bit vpat(input int f, input int cyc);
    if (f == 1) return (cyc % 3) != 2;
    if (f == 4) return (cyc % 5) < 2;
    return 1'b1;
  endfunction

  function automatic bit rpat(input int f, input int cyc);
    if (f == 2) return cyc >= 40;
    if (f == 3) return (cyc % 2) == 0;
    if (f == 4) return (cyc % 7) != 3;
    return 1'b1;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset in_ready", int'(in_ready), 1);
    check("R7 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int f = 0; f < NFR; f++) begin
      int acc, emit, cyc;
      bit seen;
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++)
          img[r][c] = pattern(f, r, c);
      acc = 0; emit = 0; cyc = 0; seen = 0;
      while (emit < NP) begin
        @(negedge clk);
        in_valid  = (acc < NP) && vpat(f, cyc);
        in_pix    = 8'(img[(acc < NP ? acc : 0) / W][(acc < NP ? acc : 0) % W]);
        out_ready = rpat(f, cyc);
        #1;
        if (!out_ready)
          check("R1 in_ready limit", int'(in_ready), int'((acc < NP) && (acc - emit < W + 2)));
        if (out_valid && !seen) begin
          seen = 1;
          check("R2 first output latency", acc, W + 2);
        end
        if (out_valid && out_ready) begin
          check($sformatf("R3 R4 R5 pixel f%0d r%0d c%0d", f, emit / W, emit % W),
                int'(out_pix), expect_out(emit / W, emit % W));
          check("R6 out_sof", int'(out_sof), int'(emit == 0));
          check("R6 out_eol", int'(out_eol), int'(emit % W == W - 1));
          emit++;
        end
        if (in_valid && in_ready) acc++;
        cyc++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      #1;
      check("R7 R8 input count per frame", acc, NP);
      check("R7 drained out_valid", int'(out_valid), 0);
      check("R9 ready for next frame", int'(in_ready), 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule